// File: doc/BRIEF.md
# Departure-Aware Bank Allocator for a Shared-Memory Switch

This block decides where each arriving cell is stored in a switch whose cell buffer is split into K single-ported banks. Each bank can do one access per time slot, either a read or a write. Up to N cells arrive in each slot, one per input lane, and each is tagged with its destination output. The block gives each cell the departure slot that a first-in first-out output-queued switch would give it. It then picks a bank that is idle in the current slot and that no other cell leaving in the same future slot already uses. With K = 3N-1 banks, such a bank always exists.

One clock cycle is one slot. A circular calendar of W entries holds the future reservations. Each entry records, for every output, whether a cell leaves in that slot and from which bank. In each slot the entry for the current slot drives the per-output read commands and is then cleared. A per-output backlog counter gives the distance from the current slot to that output's last assigned departure. A cell whose departure would fall W or more slots ahead is refused. A two-state controller, `ST_RUN` and `ST_FAULT`, keeps a sticky error flag. Any allocation failure (no free bank) causes the transition `ST_RUN -> ST_FAULT`. `ST_FAULT` has no exit other than reset.

Top module: `bank_alloc_top`

## Requirements
- R1: After reset, `cur_slot` is 0, every `rd_valid` bit is low, `alloc_err` is low, and every output backlog is empty, so the first cell to any output departs at the current slot plus one.
- R2: A cell arriving in slot t for output o departs in slot max(t+1, L+1), where L is the last departure slot given to output o. If several lanes target the same output in one slot, they get consecutive slots in ascending lane order. `grant_slot` carries the absolute departure slot modulo 2^TW.
- R3: In any slot, no bank is granted to two arriving cells, and no granted bank is one that a read command uses in that slot.
- R4: A granted bank is never one already reserved by another cell that departs in the same slot as the granted cell.
- R5: Lanes are served lowest index first. Each cell gets the lowest-numbered bank, as a binary index, that is free of the R3 and R4 exclusions, counting the cells granted earlier in the same slot.
- R6: If a cell's departure slot minus the current slot is W or more, `arr_stall` is raised for that lane and no grant is given. The refused cell changes no backlog and no reservation.
- R7: In slot t, `rd_valid[o]` is high exactly when a cell for output o was granted with departure slot t. `rd_bank` field o (bits [o*BW +: BW]) then holds that cell's bank. An entry is cleared once read, so it is never reissued W slots later.
- R8: An arrival whose output tag is N or more gets neither a grant nor a stall, and it leaves the backlogs and reservations unchanged.
- R9: `alloc_err` rises when a valid, in-window cell finds no free bank and then stays high until reset. With K = 3N-1 it stays low under any arrival pattern.
- R10: `cur_slot` increases by one every clock cycle after reset and wraps modulo 2^TW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | N | One bit per lane: a cell arrives in this slot |
| arr_out | input | N*PW | Destination output per lane, lane i at [i*PW +: PW] |
| grant_valid | output | N | Lane's cell was given a bank |
| grant_bank | output | N*BW | Granted bank index per lane |
| grant_slot | output | N*TW | Absolute departure slot per lane |
| arr_stall | output | N | Lane's cell refused: departure beyond the calendar window |
| rd_valid | output | N | Per output: a cell leaves in this slot |
| rd_bank | output | N*BW | Per output: bank to read in this slot |
| cur_slot | output | TW | Current slot number |
| alloc_err | output | 1 | Sticky flag: no free bank was found |

## Verification
The assertions assume that `arr_valid` and `arr_out` are known and stable around every rising edge once reset is released. They also assume that K keeps its derived value 3N-1, which is what makes an allocation failure unreachable and lets the no-failure and no-clash properties hold for arbitrary traffic. The bench drives all inputs on the falling edge and holds them for the whole slot. It keeps `arr_valid` low while reset is asserted. It uses output tags inside the 2-bit field, with the value 3 deliberately used as the out-of-range case. Its reference model tracks each output's last departure and each future slot's reservations as plain integers keyed by absolute slot.

// File: rtl/bank_alloc_pkg.sv
package bank_alloc_pkg;

    // Controller states for the sticky allocation-error tracker
    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } alloc_state_e;

endpackage

// File: rtl/bank_pick.sv
// Lowest-index selector over a free-bank vector.
module bank_pick #(
    parameter int K  = 8,
    parameter int BW = 3
) (
    input  logic [K-1:0]  free_banks,
    output logic          found,
    output logic [BW-1:0] bank
);

    always_comb begin
        found = 1'b0;
        bank  = '0;
        // scan downward so that the lowest free index is written last
        for (int b = K - 1; b >= 0; b--) begin
            if (free_banks[b]) begin
                found = 1'b1;
                bank  = BW'(b);
            end
        end
    end

endmodule

// File: rtl/bank_alloc_stage.sv
// One lane of the allocation chain: departure slot, window check, bank choice.
module bank_alloc_stage #(
    parameter int N   = 3,
    parameter int W   = 16,
    parameter int K   = 8,
    parameter int PW  = 2,
    parameter int BW  = 3,
    parameter int OW  = 5,
    parameter int WIW = 4,
    parameter int TW  = 16
) (
    input  logic            cell_v,
    input  logic [PW-1:0]   cell_o,
    input  logic [WIW-1:0]  idx,
    input  logic [TW-1:0]   slot,
    input  logic [N*OW-1:0] pend_in,
    input  logic [W*K-1:0]  amask_in,
    input  logic [K-1:0]    used_in,
    output logic [N*OW-1:0] pend_out,
    output logic [W*K-1:0]  amask_out,
    output logic [K-1:0]    used_out,
    output logic            grant,
    output logic            stall,
    output logic            fail,
    output logic [BW-1:0]   bank,
    output logic [TW-1:0]   dep_slot,
    output logic [WIW-1:0]  dep_idx
);

    logic          in_range;
    logic [OW-1:0] backlog;
    logic [OW-1:0] off;
    logic          too_far;
    logic [K-1:0]  excl;
    logic          found;
    int            sum;

    always_comb begin
        in_range = cell_v && (int'(cell_o) < N);
        backlog  = '0;
        for (int o = 0; o < N; o++) begin
            if (int'(cell_o) == o) backlog = pend_in[o*OW +: OW];
        end
        off     = backlog + 1'b1;
        too_far = int'(off) >= W;
        sum     = int'(idx) + int'(off);
        if (sum >= W) sum = sum - W;
        dep_idx  = WIW'(sum);
        dep_slot = slot + TW'(off);
        excl     = used_in | amask_in[int'(dep_idx)*K +: K];
    end

    bank_pick #(.K(K), .BW(BW)) u_pick (
        .free_banks (~excl),
        .found      (found),
        .bank       (bank)
    );

    always_comb begin
        grant = in_range && !too_far && found;
        stall = in_range && too_far;
        fail  = in_range && !too_far && !found;

        pend_out  = pend_in;
        amask_out = amask_in;
        used_out  = used_in;
        if (grant) begin
            for (int o = 0; o < N; o++) begin
                if (int'(cell_o) == o) pend_out[o*OW +: OW] = off;
            end
            amask_out[int'(dep_idx)*K + int'(bank)] = 1'b1;
            used_out[bank] = 1'b1;
        end
    end

endmodule

// File: rtl/bank_alloc_top.sv
module bank_alloc_top
    import bank_alloc_pkg::*;
#(
    parameter int N  = 3,
    parameter int W  = 16,
    parameter int TW = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N-1:0]                 arr_valid,
    input  logic [N*((N>1)?$clog2(N):1)-1:0] arr_out,
    output logic [N-1:0]                 grant_valid,
    output logic [N*$clog2(3*N-1)-1:0]   grant_bank,
    output logic [N*TW-1:0]              grant_slot,
    output logic [N-1:0]                 arr_stall,
    output logic [N-1:0]                 rd_valid,
    output logic [N*$clog2(3*N-1)-1:0]   rd_bank,
    output logic [TW-1:0]                cur_slot,
    output logic                         alloc_err
);

    localparam int K   = 3 * N - 1;
    localparam int PW  = (N > 1) ? $clog2(N) : 1;
    localparam int BW  = $clog2(K);
    localparam int WIW = $clog2(W);
    localparam int OW  = $clog2(W) + 1;

    // ---------------- state ----------------
    logic [TW-1:0]   slot_q;
    logic [WIW-1:0]  idx_q;
    logic [N*OW-1:0] pend_q;
    logic [K-1:0]    cal_mask [W];
    logic [N-1:0]    cal_v    [W];
    logic [BW-1:0]   cal_b    [W][N];
    alloc_state_e    state_q, state_d;

    // ---------------- allocation chain ----------------
    logic [N*OW-1:0] pend_c  [N+1];
    logic [W*K-1:0]  amask_c [N+1];
    logic [K-1:0]    used_c  [N+1];
    logic [W*K-1:0]  amask_init;
    logic [K-1:0]    read_mask;

    logic [N-1:0]    g, st, f;
    logic [BW-1:0]   bk [N];
    logic [TW-1:0]   ds [N];
    logic [WIW-1:0]  di [N];
    logic [PW-1:0]   lane_o [N];

    always_comb begin
        for (int e = 0; e < W; e++) amask_init[e*K +: K] = cal_mask[e];
        read_mask = cal_mask[idx_q];
    end

    assign pend_c[0]  = pend_q;
    assign amask_c[0] = amask_init;
    assign used_c[0]  = read_mask;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_lane
            assign lane_o[i] = arr_out[i*PW +: PW];

            bank_alloc_stage #(
                .N(N), .W(W), .K(K), .PW(PW), .BW(BW),
                .OW(OW), .WIW(WIW), .TW(TW)
            ) u_stage (
                .cell_v    (arr_valid[i]),
                .cell_o    (lane_o[i]),
                .idx       (idx_q),
                .slot      (slot_q),
                .pend_in   (pend_c[i]),
                .amask_in  (amask_c[i]),
                .used_in   (used_c[i]),
                .pend_out  (pend_c[i+1]),
                .amask_out (amask_c[i+1]),
                .used_out  (used_c[i+1]),
                .grant     (g[i]),
                .stall     (st[i]),
                .fail      (f[i]),
                .bank      (bk[i]),
                .dep_slot  (ds[i]),
                .dep_idx   (di[i])
            );

            assign grant_valid[i]             = g[i];
            assign arr_stall[i]               = st[i];
            assign grant_bank[i*BW +: BW]     = bk[i];
            assign grant_slot[i*TW +: TW]     = ds[i];

            AST_DEP_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
                g[i] |-> !cal_mask[di[i]][bk[i]]);                          // R4
            AST_DEP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
                g[i] |-> ((ds[i] - slot_q) != '0) && (int'(TW'(ds[i] - slot_q)) < W)); // R6
            AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({g[i], st[i], f[i]}));                            // R5
        end
    endgenerate

    // ---------------- calendar, backlog, slot registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            idx_q  <= '0;
            pend_q <= '0;
            for (int e = 0; e < W; e++) begin
                cal_mask[e] <= '0;
                cal_v[e]    <= '0;
                for (int o = 0; o < N; o++) cal_b[e][o] <= '0;
            end
        end else begin
            slot_q <= slot_q + 1'b1;
            idx_q  <= (idx_q == WIW'(W - 1)) ? '0 : idx_q + 1'b1;
            for (int o = 0; o < N; o++) begin
                pend_q[o*OW +: OW] <= (pend_c[N][o*OW +: OW] == '0) ? '0
                                      : pend_c[N][o*OW +: OW] - 1'b1;
            end
            for (int e = 0; e < W; e++) cal_mask[e] <= amask_c[N][e*K +: K];
            // the current entry has been read this slot: retire it
            cal_mask[idx_q] <= '0;
            cal_v[idx_q]    <= '0;
            for (int l = 0; l < N; l++) begin
                if (g[l]) begin
                    cal_v[di[l]][lane_o[l]] <= 1'b1;
                    cal_b[di[l]][lane_o[l]] <= bk[l];
                end
            end
        end
    end

    // ---------------- read commands ----------------
    always_comb begin
        for (int o = 0; o < N; o++) begin
            rd_valid[o]           = cal_v[idx_q][o];
            rd_bank[o*BW +: BW]   = cal_b[idx_q][o];
        end
    end

    assign cur_slot = slot_q;

    // ---------------- error controller ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (|f) state_d = ST_FAULT;
            ST_FAULT: state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        alloc_err = (state_q == ST_FAULT);
    end

    // ---------------- port-level checks ----------------
    logic         bank_clash;
    logic [K-1:0] seen;

    always_comb begin
        bank_clash = 1'b0;
        seen       = '0;
        for (int o = 0; o < N; o++) begin
            if (rd_valid[o]) begin
                if (seen[rd_bank[o*BW +: BW]]) bank_clash = 1'b1;
                seen[rd_bank[o*BW +: BW]] = 1'b1;
            end
        end
        for (int l = 0; l < N; l++) begin
            if (grant_valid[l]) begin
                if (seen[grant_bank[l*BW +: BW]]) bank_clash = 1'b1;
                seen[grant_bank[l*BW +: BW]] = 1'b1;
            end
        end
    end

    AST_NO_BANK_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_clash);                                                       // R3
    AST_NO_ALLOC_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|f));                                                             // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_err |=> alloc_err);                                           // R9

endmodule

// File: tb/tb_bank_alloc_top.sv
module tb_bank_alloc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 3;
    localparam int WD = 16;
    localparam int KB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  arr_valid = '0;
    logic [5:0]  arr_out = '0;
    logic [2:0]  grant_valid;
    logic [8:0]  grant_bank;
    logic [47:0] grant_slot;
    logic [2:0]  arr_stall;
    logic [2:0]  rd_valid;
    logic [8:0]  rd_bank;
    logic [15:0] cur_slot;
    logic        alloc_err;

    int checks = 0;
    int errors = 0;
    int mslot  = 0;
    int mlast [NP];
    int mv    [64][NP];
    int mb    [64][NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_alloc_top dut (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_out(arr_out),
        .grant_valid(grant_valid), .grant_bank(grant_bank), .grant_slot(grant_slot),
        .arr_stall(arr_stall), .rd_valid(rd_valid), .rd_bank(rd_bank),
        .cur_slot(cur_slot), .alloc_err(alloc_err)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int busy_at(input int dep);
        int m = 0;
        for (int o = 0; o < NP; o++)
            if (mv[dep % 64][o] != 0) m |= (1 << mb[dep % 64][o]);
        return m;
    endfunction

    // one slot: drive at falling edge, check combinational outputs, advance model
    task automatic step(input bit [2:0] v, input int o0, input int o1, input int o2);
        int oo [NP];
        int t, used, dep, busy, bnk, dutb;
        oo[0] = o0; oo[1] = o1; oo[2] = o2;
        @(negedge clk);
        arr_valid = v;
        arr_out   = {2'(o2), 2'(o1), 2'(o0)};
        #1;
        t = mslot;
        chk("R10", "cur_slot", cur_slot, t & 16'hFFFF);
        used = 0;
        for (int o = 0; o < NP; o++) begin
            chk("R7", "rd_valid", rd_valid[o], mv[t % 64][o] != 0);
            if (mv[t % 64][o] != 0) begin
                chk("R7", "rd_bank", rd_bank[o*3 +: 3], mb[t % 64][o]);
                used |= (1 << mb[t % 64][o]);
            end
        end
        for (int i = 0; i < NP; i++) begin
            if (v[i] && oo[i] < NP) begin
                dep = (t + 1 > mlast[oo[i]] + 1) ? t + 1 : mlast[oo[i]] + 1;
                if (dep - t >= WD) begin
                    chk("R6", "arr_stall", arr_stall[i], 1);
                    chk("R6", "grant_valid when refused", grant_valid[i], 0);
                end else begin
                    busy = busy_at(dep);
                    bnk = -1;
                    for (int b = KB - 1; b >= 0; b--)
                        if ((((used | busy) >> b) & 1) == 0) bnk = b;
                    dutb = grant_bank[i*3 +: 3];
                    chk("R2", "grant_valid", grant_valid[i], 1);
                    chk("R2", "grant_slot", grant_slot[i*16 +: 16], dep & 16'hFFFF);
                    chk("R5", "grant_bank", dutb, bnk);
                    chk("R3", "bank busy now", (used >> dutb) & 1, 0);
                    chk("R4", "bank busy at departure", (busy >> dutb) & 1, 0);
                    mv[dep % 64][oo[i]] = 1;
                    mb[dep % 64][oo[i]] = bnk;
                    used |= (1 << bnk);
                    mlast[oo[i]] = dep;
                end
            end else begin
                chk("R8", "grant_valid idle/out-of-range", grant_valid[i], 0);
                chk("R8", "arr_stall idle/out-of-range", arr_stall[i], 0);
            end
        end
        chk("R9", "alloc_err", alloc_err, 0);
        for (int o = 0; o < NP; o++) mv[t % 64][o] = 0;
        mslot++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(3'b000, 0, 0, 0);
    endtask

    task automatic t_reset;
        for (int o = 0; o < NP; o++) mlast[o] = 0;
        for (int s = 0; s < 64; s++)
            for (int o = 0; o < NP; o++) begin mv[s][o] = 0; mb[s][o] = 0; end
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "cur_slot in reset", cur_slot, 0);
        chk("R1", "rd_valid in reset", rd_valid, 0);
        chk("R1", "alloc_err in reset", alloc_err, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "cur_slot after release", cur_slot, 0);
        chk("R1", "grant_valid idle", grant_valid, 0);
        mslot = 1;   // slot 0 passes with no arrivals
    endtask

    task automatic t_single;
        step(3'b001, 1, 0, 0);   // R1: empty backlog, departs next slot
        step(3'b000, 0, 0, 0);   // read appears here (R7)
        idle(2);
    endtask

    task automatic t_fifo_burst;
        step(3'b111, 0, 0, 0);   // R2: consecutive departures in lane order
        step(3'b111, 0, 0, 0);
        idle(8);
    endtask

    task automatic t_mixed;
        step(3'b111, 0, 1, 2);
        step(3'b111, 2, 1, 0);
        step(3'b101, 1, 0, 1);
        step(3'b011, 2, 2, 0);
        step(3'b110, 0, 0, 1);
        idle(6);
    endtask

    task automatic t_out_of_range;
        step(3'b111, 3, 1, 3);   // R8: lanes 0 and 2 carry tag 3
        step(3'b010, 0, 3, 0);
        step(3'b001, 1, 0, 0);   // R8: backlog of output 1 unaffected
        idle(4);
    endtask

    task automatic t_backpressure;
        for (int k = 0; k < 9; k++) step(3'b111, 2, 2, 2);   // R6: backlog grows past window
        step(3'b111, 2, 0, 1);
        idle(WD + 4);   // R7: drain, no stale reads after wrap
    endtask

    task automatic t_random;
        for (int k = 0; k < 300; k++)
            step(3'($urandom_range(0, 7)), $urandom_range(0, 3),
                 $urandom_range(0, 3), $urandom_range(0, 2));
        idle(WD + 2);
    endtask

    initial begin
        t_reset();
        t_single();
        t_fifo_burst();
        t_mixed();
        t_out_of_range();
        t_backpressure();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule